// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 20-bit buses, called side A and side B, with one independent control group per direction. Each direction holds its data in a single storage cell per bit. That cell can act as an open latch, a frozen latch, or a clock-enabled register that captures on a rising edge of a per-direction transfer strobe. The direction's latch enable selects the behaviour on every cycle. The last stage of each direction is an active-low output enable that either drives the destination side or releases it.

The whole block runs on one system clock. Each transfer strobe is an ordinary input that is sampled on that clock, and a rising edge is detected when the strobe is seen low and then high. Tristate buses are modelled as a data vector plus a drive-enable bit for each side. While a side is released, its data vector reads zero. Storage has no reset: its contents are undefined until a value is loaded, either through the open latch or through a strobe capture.

Top module: `bus_xcvr20`

## Requirements
- R1: While a direction's latch enable is 1 and its output is enabled, the destination data equals the source data in the same cycle (open latch).
- R2: When the latch enable drops to 0, the cell keeps the source value that was present at the last system-clock edge with the latch enable at 1. Later source changes do not appear.
- R3: While the latch enable is 0 and the active-low clock enable is 1, the stored value does not change, whatever the transfer strobe does.
- R4: While the latch enable is 0 and the clock enable is 0, a rising edge of the transfer strobe captures the source data. An edge is a strobe seen at 0 on one system-clock edge and at 1 on the next. The captured value appears at the destination directly after the clock edge that sees the strobe at 1.
- R5: A transfer strobe that stays at 0 or stays at 1 never changes the stored value.
- R6: Output enable is active low. With it at 0, the destination drive-enable is 1 and the data shows the cell. With it at 1, the drive-enable is 0 and the data reads all zeros.
- R7: The storage cell keeps loading and capturing while its output is disabled. When the output is enabled again, it shows the latest stored value.
- R8: The two directions are independent. Side B is driven only by the A-to-B group, and side A only by the B-to-A group.
- R9: A synchronous active-low reset clears the edge detectors so that no capture happens right after reset. The bus width is set by a parameter with a default of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 20 | Data received from side A |
| a_out | output | 20 | Data driven onto side A (zeros when released) |
| a_oe | output | 1 | Drive enable for side A |
| b_in | input | 20 | Data received from side B |
| b_out | output | 20 | Data driven onto side B (zeros when released) |
| b_oe | output | 1 | Drive enable for side B |
| ab_le | input | 1 | A-to-B latch enable, 1 = open |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_strb | input | 1 | A-to-B transfer strobe |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = open |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_strb | input | 1 | B-to-A transfer strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Every cycle, the assertions check that a frozen latch or a static strobe leaves the stored value unchanged, and that an open latch or a detected edge loads exactly the previous source value. They also check that the edge detector never flags two edges in a row. Other behaviours are visible only in the bench scenarios: the same-cycle pass-through, the released-port zeros, updates made while the output is disabled, and the independence of the two directions. These show at the ports only after a known value has been loaded into storage.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the bus transceiver.
// Assumes: one system clock; per-direction controls are sampled on it.
package xcvr_pkg;
    localparam int XCVR_W_DEFAULT = 20;

    // Behaviour chosen for a storage cell in a given cycle.
    typedef enum logic [1:0] {
        CELL_OPEN    = 2'd0,
        CELL_FROZEN  = 2'd1,
        CELL_CLOCKED = 2'd2
    } cell_mode_e;
endpackage

// File: rtl/xcvr_strobe_edge.sv
// Rising-edge detector for a transfer strobe sampled on the system clock.
// Assumes: the strobe is synchronous to clk. Reset presets the history to 1
// so that a strobe already high at reset release does not count as an edge.
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic rise
);
    logic strb_q;

    // Remember the strobe level from the previous system-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b1;
        else        strb_q <= strb;
    end

    assign rise = strb & ~strb_q;

    // R4: a rising edge needs a low sample first, so two in a row are impossible
    assert_edge_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/xcvr_store_cell.sv
// One storage cell per bit: open latch, frozen latch or edge register.
// Assumes: storage has no reset; contents are undefined until loaded.
module xcvr_store_cell
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         ce_n,
    input  logic         strb,
    output logic [W-1:0] dout
);
    logic         rise;
    logic         load;
    cell_mode_e   mode;
    logic [W-1:0] held_q;

    xcvr_strobe_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .strb  (strb),
        .rise  (rise)
    );

    // Decode this cycle's behaviour from the latch and clock enables.
    always_comb begin
        if (le)         mode = CELL_OPEN;
        else if (ce_n)  mode = CELL_FROZEN;
        else            mode = CELL_CLOCKED;
    end

    assign load = (mode == CELL_OPEN) || ((mode == CELL_CLOCKED) && rise);

    // Storage element without reset; loads when open or on a strobe edge.
    always_ff @(posedge clk) begin
        if (load) held_q <= din;
    end

    // Open latch passes the source through in the same cycle.
    assign dout = (mode == CELL_OPEN) ? din : held_q;

    // R3: frozen latch keeps its value whatever the strobe does
    assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ce_n) |=> $stable(held_q));
    // R5: a static strobe in clocked mode never alters storage
    assert_static_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ce_n && !strb) |=> $stable(held_q));
    // R2: open latch stores the value present at the clock edge
    assert_open_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (held_q == $past(din)));
    // R4: a detected edge with clock enable low captures the source
    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ce_n && rise) |=> (held_q == $past(din)));
endmodule

// File: rtl/xcvr_drive.sv
// Output stage: an active-low enable gates data and drive-enable to a side.
// Assumes: a released side reads zeros on its data vector.
module xcvr_drive #(
    parameter int W = 20
) (
    input  logic [W-1:0] din,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         oe
);
    // Gate the data onto the side only while the enable is asserted.
    always_comb begin
        oe   = ~oe_n;
        dout = oe_n ? '0 : din;
    end
endmodule

// File: rtl/bus_xcvr20.sv
// Top: two independent direction paths, A-to-B and B-to-A.
// Assumes: all controls synchronous to clk; rst_n synchronous active low.
module bus_xcvr20
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_le,
    input  logic         ab_ce_n,
    input  logic         ab_strb,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_ce_n,
    input  logic         ba_strb,
    input  logic         ba_oe_n
);
    logic [W-1:0] ab_cell;
    logic [W-1:0] ba_cell;

    xcvr_store_cell #(.W(W)) ab_cell_i (
        .clk(clk), .rst_n(rst_n), .din(a_in), .le(ab_le),
        .ce_n(ab_ce_n), .strb(ab_strb), .dout(ab_cell)
    );
    xcvr_drive #(.W(W)) ab_drv_i (
        .din(ab_cell), .oe_n(ab_oe_n), .dout(b_out), .oe(b_oe)
    );

    xcvr_store_cell #(.W(W)) ba_cell_i (
        .clk(clk), .rst_n(rst_n), .din(b_in), .le(ba_le),
        .ce_n(ba_ce_n), .strb(ba_strb), .dout(ba_cell)
    );
    xcvr_drive #(.W(W)) ba_drv_i (
        .din(ba_cell), .oe_n(ba_oe_n), .dout(a_out), .oe(a_oe)
    );
endmodule

// File: tb/bus_xcvr20_tb_top.sv
// Directed bench for bus_xcvr20: one task per scenario.
module bus_xcvr20_tb_top;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe;
    logic ab_le, ab_ce_n, ab_strb, ab_oe_n;
    logic ba_le, ba_ce_n, ba_strb, ba_oe_n;
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bus_xcvr20 #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ab_strb(ab_strb), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_ce_n(ba_ce_n), .ba_strb(ba_strb), .ba_oe_n(ba_oe_n)
    );

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then wait one rising edge and settle.
    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_le = 0; ab_ce_n = 1; ab_strb = 1; ab_oe_n = 1;
        ba_le = 0; ba_ce_n = 1; ba_strb = 1; ba_oe_n = 1;
        step(); step();
        rst_n = 1'b1;
        step();
        check("R6 reset b_oe", {{(W-1){1'b0}}, b_oe}, '0);
        check("R6 reset a_oe", {{(W-1){1'b0}}, a_oe}, '0);
        check("R6 reset b_out", b_out, '0);
    endtask

    task automatic t_transparent();
        ab_oe_n = 0; ab_le = 1; a_in = 20'hA5A5A;
        #1 check("R1 pass-through", b_out, 20'hA5A5A);
        a_in = 20'h0F0F1;
        #1 check("R1 pass-through change", b_out, 20'h0F0F1);
        check("R6 b_oe on", {{(W-1){1'b0}}, b_oe}, 20'h1);
        step();
    endtask

    task automatic t_latch();
        a_in = 20'h12345;
        step();
        ab_le = 0; ab_ce_n = 1;
        a_in = 20'hFFFFF;
        #1 check("R2 latch closes", b_out, 20'h12345);
        step();
        check("R2 latch holds", b_out, 20'h12345);
    endtask

    task automatic t_ce_hold();
        for (int i = 0; i < 4; i++) begin
            ab_strb = ~ab_strb;
            a_in = 20'h0ABC0 + i;
            step();
        end
        check("R3 frozen ignores strobe", b_out, 20'h12345);
    endtask

    task automatic t_clocked();
        ab_ce_n = 0; ab_strb = 0; a_in = 20'h77777;
        step();
        check("R4 low strobe no capture", b_out, 20'h12345);
        ab_strb = 1;
        step();
        check("R4 rising edge captures", b_out, 20'h77777);
    endtask

    task automatic t_static();
        a_in = 20'h33333;
        step(); step();
        check("R5 static high holds", b_out, 20'h77777);
        ab_strb = 0;
        step(); step();
        check("R5 static low holds", b_out, 20'h77777);
    endtask

    task automatic t_oe_off_update();
        ab_oe_n = 1;
        #1 check("R6 released zeros", b_out, '0);
        check("R6 b_oe off", {{(W-1){1'b0}}, b_oe}, '0);
        a_in = 20'h5A5A5; ab_strb = 1;
        step();
        check("R7 released during capture", b_out, '0);
        ab_oe_n = 0;
        #1 check("R7 update while disabled", b_out, 20'h5A5A5);
        step();
    endtask

    task automatic t_independent();
        ba_le = 1; ba_oe_n = 0; b_in = 20'hC0FFE;
        step();
        ba_le = 0; ba_ce_n = 1; b_in = 20'h00001;
        a_in = 20'hDEAD0; ab_le = 1;
        step();
        check("R8 a side holds own value", a_out, 20'hC0FFE);
        check("R8 b side follows A", b_out, 20'hDEAD0);
        check("R8 a_oe from B-to-A group", {{(W-1){1'b0}}, a_oe}, 20'h1);
        ab_oe_n = 1;
        #1 check("R8 a side unaffected by ab_oe_n", a_out, 20'hC0FFE);
        step();
    endtask

    // R9: strobe held high through reset must not capture on release
    task automatic t_reset_edge();
        ab_oe_n = 0; ab_le = 1; a_in = 20'h11111;
        step();
        ab_le = 0; ab_ce_n = 0; ab_strb = 1; rst_n = 0;
        step();
        a_in = 20'h22222; rst_n = 1;
        step(); step();
        check("R9 no edge after reset", b_out, 20'h11111);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_transparent();
                t_latch();
                t_ce_hold();
                t_clocked();
                t_static();
                t_oe_off_update();
                t_independent();
                t_reset_edge();
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule